// File: doc/BRIEF.md
# Stage Counter and Branch Unit

This block works out the next program counter for a small coprocessor. It also holds the stage counter, an 8-bit loop counter that has its own instructions to add an immediate, subtract an immediate or clear it. Each clock cycle the block sees the instruction being executed, the current PC, the value of R0, one selected register value and the zero and overflow flags left by the previous ALU operation. From these it produces the next PC in the same cycle.

Relative branches compare either R0 or the stage counter against a 15-bit immediate. The test can be less-than, strictly greater-than or equal. If the test passes, the branch moves the PC forward or backward by up to 127 words. Absolute branches jump to an immediate address or to an address held in a register. They can be unconditional, or depend on the zero flag or the overflow flag. Instruction fetch, the register file, the main ALU and memory are outside this block. One instruction is treated as executed on every rising clock edge.

Top module: `stage_branch_unit`

## Requirements
- R1: While reset is low at a clock edge, the stage counter becomes 0.
- R2: A stage-counter instruction has opcode 7 in bits [31:28] and sub-opcode 2 in bits [27:26]. With operation select 0 in bits [24:21], it adds the low 8 bits of the 16-bit immediate in bits [19:4] to the counter, modulo 256. The new value is visible after the next rising edge.
- R3: Operation select 1 subtracts the low 8 bits of the immediate from the counter, modulo 256.
- R4: Operation select 2 clears the counter to 0. Every other select code leaves the counter unchanged.
- R5: Any instruction that is not a stage-counter instruction leaves the counter unchanged. This includes branches.
- R6: A relative branch has opcode 8 in bits [31:28]. With sub-opcode 0 in bits [27:26], it compares the 16-bit R0 value, unsigned, against the zero-extended immediate in bits [14:0]. The compare code in bits [17:15] is 1 for less-than, 2 for strictly greater-than and 4 for equal. Any other code is never taken.
- R7: Sub-opcode 2 applies the same compare codes to the zero-extended stage counter instead of R0.
- R8: A taken relative branch gives PC plus the 7-bit magnitude in bits [24:18] when bit 25 is 0, and PC minus that magnitude when bit 25 is 1. The result wraps modulo 2048.
- R9: Sub-opcode 1 is an absolute branch. Its target is the 11-bit immediate in bits [12:2], or the low 11 bits of the register input when bit 21 is 1. The type field in bits [24:22] selects the condition: 0 is always taken, 1 is taken if the zero flag is set, 2 is taken if the overflow flag is set, and any other type is never taken.
- R10: A branch that is not taken, opcode 8 with sub-opcode 3, and every non-branch instruction give PC+1 modulo 2048. The next PC is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction executed this cycle |
| pc_i | input | 11 | Current program counter |
| r0_i | input | 16 | Value of register R0 |
| reg_i | input | 16 | Register selected by the absolute branch |
| zero_i | input | 1 | Last ALU result was zero |
| ovf_i | input | 1 | Last ALU operation overflowed |
| next_pc_o | output | 11 | Next program counter |
| stage_o | output | 8 | Stage counter value |

## Verification
The bench checks the edges of each compare. An equal operand must not take a greater-than branch: a design that treats code 2 as greater-or-equal would branch there. R0 values with bit 15 set must compare above every immediate: a design that sign-extends the immediate, or truncates R0 to 15 bits, gets those cases wrong. The bench steps the stage counter through wrap-around in both directions and applies an unused select code; a design that wraps or decodes wrongly shows the wrong count. Backward offsets from PC 5, forward offsets near 2047, and PC 2047 falling through to 0 expose mistakes in the sign handling and in the PC wrap. Absolute branches are run with both flag values and with a reserved type, which catches a design that swaps the zero and overflow flags or takes unknown types.

// File: rtl/sbu_pkg.sv
// Package: shared encodings and the decoded-instruction record for the
// stage counter and branch unit. Field positions are fixed by the
// instruction format, so they live in the decoder, not here.
package sbu_pkg;

    localparam logic [3:0] OPC_ALU    = 4'd7;
    localparam logic [3:0] OPC_BRANCH = 4'd8;
    localparam logic [1:0] SUB_STAGE  = 2'd2;
    localparam logic [1:0] SUB_REL_R0 = 2'd0;
    localparam logic [1:0] SUB_ABS    = 2'd1;
    localparam logic [1:0] SUB_REL_ST = 2'd2;

    typedef enum logic [3:0] {
        CNT_ADD = 4'd0,
        CNT_SUB = 4'd1,
        CNT_CLR = 4'd2
    } cnt_op_e;

    typedef enum logic [2:0] {
        CMP_LT = 3'd1,
        CMP_GT = 3'd2,
        CMP_EQ = 3'd4
    } cmp_code_e;

    typedef enum logic [2:0] {
        JMP_ALWAYS = 3'd0,
        JMP_ZERO   = 3'd1,
        JMP_OVF    = 3'd2
    } jmp_type_e;

    typedef struct packed {
        logic        is_cnt;
        logic [3:0]  cnt_sel;
        logic [15:0] cnt_imm;
        logic        is_rel;
        logic        rel_stage;
        logic [14:0] rel_imm;
        logic [2:0]  rel_code;
        logic [6:0]  rel_off;
        logic        rel_back;
        logic        is_abs;
        logic        abs_use_reg;
        logic [2:0]  abs_type;
        logic [10:0] abs_addr;
    } sbu_dec_t;

endpackage

// File: rtl/sbu_decode.sv
// Module: sbu_decode
// Splits the 32-bit instruction word into the fields used by the stage
// counter, the relative branch and the absolute branch.
// Assumes: fields of different formats overlap; consumers look only at
// the fields whose class flag is set.
module sbu_decode
    import sbu_pkg::*;
(
    input  logic [31:0] instr_i,
    output sbu_dec_t    dec_o
);

    logic [3:0] opc;
    logic [1:0] sub;

    assign opc = instr_i[31:28];
    assign sub = instr_i[27:26];

    // Field extraction and instruction classification.
    always_comb begin
        dec_o             = '0;
        dec_o.is_cnt      = (opc == OPC_ALU) && (sub == SUB_STAGE);
        dec_o.cnt_sel     = instr_i[24:21];
        dec_o.cnt_imm     = instr_i[19:4];
        dec_o.is_rel      = (opc == OPC_BRANCH) &&
                            ((sub == SUB_REL_R0) || (sub == SUB_REL_ST));
        dec_o.rel_stage   = (sub == SUB_REL_ST);
        dec_o.rel_imm     = instr_i[14:0];
        dec_o.rel_code    = instr_i[17:15];
        dec_o.rel_off     = instr_i[24:18];
        dec_o.rel_back    = instr_i[25];
        dec_o.is_abs      = (opc == OPC_BRANCH) && (sub == SUB_ABS);
        dec_o.abs_use_reg = instr_i[21];
        dec_o.abs_type    = instr_i[24:22];
        dec_o.abs_addr    = instr_i[12:2];
    end

endmodule

// File: rtl/sbu_stage_ctr.sv
// Module: sbu_stage_ctr
// The stage loop counter. It adds or subtracts the low bits of the
// immediate, or clears to zero, only when a counter instruction is
// executed. Assumes: one instruction is executed per clock.
module sbu_stage_ctr
    import sbu_pkg::*;
#(
    parameter int STAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_en_i,
    input  logic [3:0]         sel_i,
    input  logic [15:0]        imm_i,
    output logic [STAGE_W-1:0] stage_o
);

    logic [STAGE_W-1:0] stage_q;
    logic [STAGE_W-1:0] step;
    logic               unused_imm_hi;

    assign step          = imm_i[STAGE_W-1:0];
    assign unused_imm_hi = ^imm_i;

    // Counter register: reset, then update on counter instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (op_en_i) begin
            case (sel_i)
                CNT_ADD: stage_q <= stage_q + step;
                CNT_SUB: stage_q <= stage_q - step;
                CNT_CLR: stage_q <= '0;
                default: stage_q <= stage_q;
            endcase
        end
    end

    assign stage_o = stage_q;

endmodule

// File: rtl/sbu_compare.sv
// Module: sbu_compare
// Unsigned compare of an operand against a zero-extended 15-bit
// immediate. The code picks less-than, strict greater-than or equal;
// unknown codes give no hit. Assumes DATA_W >= 15.
module sbu_compare
    import sbu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [14:0]       imm_i,
    input  logic [2:0]        code_i,
    output logic              hit_o
);

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = {{(DATA_W-15){1'b0}}, imm_i};

    // Select the relation that the compare code asks for.
    always_comb begin
        case (code_i)
            CMP_LT:  hit_o = (opnd_i <  imm_ext);
            CMP_GT:  hit_o = (opnd_i >  imm_ext);
            CMP_EQ:  hit_o = (opnd_i == imm_ext);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbu_next_pc.sv
// Module: sbu_next_pc
// Chooses between the fall-through PC, a relative target and an
// absolute target. Every result wraps modulo 2^PC_W.
// Assumes PC_W >= 7.
module sbu_next_pc #(
    parameter int PC_W = 11
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            rel_take_i,
    input  logic            rel_back_i,
    input  logic [6:0]      rel_off_i,
    input  logic            abs_take_i,
    input  logic [PC_W-1:0] abs_tgt_i,
    output logic [PC_W-1:0] next_pc_o
);

    logic [PC_W-1:0] off_ext;

    assign off_ext = {{(PC_W-7){1'b0}}, rel_off_i};

    // Priority among the absolute, relative and fall-through targets.
    always_comb begin
        if (abs_take_i)
            next_pc_o = abs_tgt_i;
        else if (rel_take_i)
            next_pc_o = rel_back_i ? (pc_i - off_ext) : (pc_i + off_ext);
        else
            next_pc_o = pc_i + PC_W'(1);
    end

endmodule

// File: rtl/stage_branch_unit.sv
// Module: stage_branch_unit (top)
// Next-PC unit for a small coprocessor. It holds the stage counter and
// resolves relative branches (R0 or the stage counter against an
// immediate) and flag-conditioned absolute branches.
// Assumes: the instruction on instr_i executes at the next rising edge;
// the next PC is combinational.
module stage_branch_unit
    import sbu_pkg::*;
#(
    parameter int PC_W    = 11,
    parameter int DATA_W  = 16,
    parameter int STAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        instr_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [DATA_W-1:0]  r0_i,
    input  logic [DATA_W-1:0]  reg_i,
    input  logic               zero_i,
    input  logic               ovf_i,
    output logic [PC_W-1:0]    next_pc_o,
    output logic [STAGE_W-1:0] stage_o
);

    localparam int NSRC = 2;

    sbu_dec_t          dec;
    logic [STAGE_W-1:0] stage_q;
    logic [DATA_W-1:0] cmp_opnd [NSRC];
    logic [NSRC-1:0]   cmp_hit;
    logic              rel_take;
    logic              abs_take;
    logic [PC_W-1:0]   abs_tgt;
    logic              unused_reg_hi;

    sbu_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    sbu_stage_ctr #(.STAGE_W(STAGE_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_en_i (dec.is_cnt),
        .sel_i   (dec.cnt_sel),
        .imm_i   (dec.cnt_imm),
        .stage_o (stage_q)
    );

    assign cmp_opnd[0] = r0_i;
    assign cmp_opnd[1] = {{(DATA_W-STAGE_W){1'b0}}, stage_q};

    // One comparator for each compare source.
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_cmp
            sbu_compare #(.DATA_W(DATA_W)) u_cmp (
                .opnd_i (cmp_opnd[g]),
                .imm_i  (dec.rel_imm),
                .code_i (dec.rel_code),
                .hit_o  (cmp_hit[g])
            );
        end
    endgenerate

    assign rel_take = dec.is_rel && cmp_hit[dec.rel_stage];

    // Absolute branch condition from the type field and the flags.
    always_comb begin
        case (dec.abs_type)
            JMP_ALWAYS: abs_take = dec.is_abs;
            JMP_ZERO:   abs_take = dec.is_abs && zero_i;
            JMP_OVF:    abs_take = dec.is_abs && ovf_i;
            default:    abs_take = 1'b0;
        endcase
    end

    assign abs_tgt       = dec.abs_use_reg ? reg_i[PC_W-1:0] : PC_W'(dec.abs_addr);
    assign unused_reg_hi = ^reg_i;

    sbu_next_pc #(.PC_W(PC_W)) u_npc (
        .pc_i       (pc_i),
        .rel_take_i (rel_take),
        .rel_back_i (dec.rel_back),
        .rel_off_i  (dec.rel_off),
        .abs_take_i (abs_take),
        .abs_tgt_i  (abs_tgt),
        .next_pc_o  (next_pc_o)
    );

    assign stage_o = stage_q;

endmodule

// File: rtl/sbu_checker.sv
// Module: sbu_checker
// Properties over the ports of stage_branch_unit. Attached by the bind
// at the end of this file.
module sbu_checker #(
    parameter int PC_W    = 11,
    parameter int STAGE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        instr_i,
    input logic [PC_W-1:0]    pc_i,
    input logic [PC_W-1:0]    next_pc_o,
    input logic [STAGE_W-1:0] stage_o
);

    logic               is_cnt;
    logic               is_br;
    logic [STAGE_W-1:0] step;
    logic               unused_chk;

    assign is_cnt     = (instr_i[31:28] == 4'd7) && (instr_i[27:26] == 2'd2);
    assign is_br      = (instr_i[31:28] == 4'd8);
    assign step       = instr_i[4 +: STAGE_W];
    assign unused_chk = ^instr_i;

    // R1: reset clears the counter.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> stage_o == '0);

    // R2: the add operation.
    a_r2_add: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cnt && instr_i[24:21] == 4'd0) |=> stage_o == $past(stage_o) + $past(step));

    // R3: the subtract operation.
    a_r3_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cnt && instr_i[24:21] == 4'd1) |=> stage_o == $past(stage_o) - $past(step));

    // R4: the clear operation.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cnt && instr_i[24:21] == 4'd2) |=> stage_o == '0);

    // R5: other instructions hold the counter.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cnt |=> $stable(stage_o));

    // R9: an unconditional immediate absolute branch hits its target.
    a_r9_abs_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && instr_i[27:26] == 2'd1 && instr_i[24:22] == 3'd0 && !instr_i[21])
        |-> next_pc_o == instr_i[12:2]);

    // R10: a non-branch instruction falls through.
    a_r10_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !is_br |-> next_pc_o == pc_i + PC_W'(1));

endmodule

bind stage_branch_unit sbu_checker #(.PC_W(PC_W), .STAGE_W(STAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .next_pc_o (next_pc_o),
    .stage_o   (stage_o)
);

// File: tb/stage_branch_unit_tb.sv
`timescale 1ns/1ps
// Directed bench: one task for each scenario. Inputs change on the
// falling edge and outputs are sampled 2 ns later.
module stage_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [10:0] pc = '0;
    logic [15:0] r0 = '0;
    logic [15:0] rv = '0;
    logic        zf = 1'b0;
    logic        of = 1'b0;
    logic [10:0] next_pc;
    logic [7:0]  stage;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stage_branch_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .pc_i      (pc),
        .r0_i      (r0),
        .reg_i     (rv),
        .zero_i    (zf),
        .ovf_i     (of),
        .next_pc_o (next_pc),
        .stage_o   (stage)
    );

    function automatic logic [31:0] f_cnt(input logic [3:0] sel, input logic [15:0] imm);
        return {4'd7, 2'd2, 1'b0, sel, 1'b0, imm, 4'd0};
    endfunction

    function automatic logic [31:0] f_rel(input logic [1:0] sub, input logic [2:0] code,
                                          input logic back, input logic [6:0] off,
                                          input logic [14:0] imm);
        return {4'd8, sub, back, off, code, imm};
    endfunction

    function automatic logic [31:0] f_abs(input logic [2:0] typ, input logic use_reg,
                                          input logic [10:0] addr);
        return {4'd8, 2'd1, 1'b0, typ, use_reg, 8'd0, addr, 2'd0};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one counter instruction, then a neutral word, and check the count.
    task automatic cnt_op(input string req, input logic [3:0] sel,
                          input logic [15:0] imm, input int exp);
        @(negedge clk) instr = f_cnt(sel, imm);
        @(negedge clk) instr = '0;
        #2 check(req, stage, exp);
    endtask

    // Apply a word with the given PC and check the combinational next PC.
    task automatic pc_case(input string req, input logic [31:0] ins,
                           input logic [10:0] p, input int exp);
        @(negedge clk);
        instr = ins;
        pc    = p;
        #2 check(req, next_pc, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        instr = f_cnt(4'd0, 16'd9);
        repeat (2) @(negedge clk);
        #2 check("R1 reset", stage, 0);
        rst_n = 1'b1;
        instr = '0;
    endtask

    task automatic t_stage_ops;
        cnt_op("R2 add", 4'd0, 16'd5, 5);
        cnt_op("R2 add wraps, high imm bits ignored", 4'd0, 16'h01FE, 3);
        cnt_op("R3 sub wraps", 4'd1, 16'd4, 255);
        cnt_op("R3 sub", 4'd1, 16'd5, 250);
        cnt_op("R4 unused select holds", 4'd3, 16'd7, 250);
        cnt_op("R4 clear", 4'd2, 16'd77, 0);
        cnt_op("R2 add setup", 4'd0, 16'd10, 10);
        // R5: a branch and an ALU word with a different sub-opcode.
        @(negedge clk) instr = f_rel(2'd2, 3'd4, 1'b0, 7'd3, 15'd10);
        @(negedge clk) instr = {4'd7, 2'd1, 1'b0, 4'd0, 1'b0, 16'd3, 4'd0};
        @(negedge clk) instr = '0;
        #2 check("R5 non-counter holds", stage, 10);
    endtask

    task automatic t_cmp_stage;   // stage is 10 here
        pc_case("R7 stage lt taken", f_rel(2'd2, 3'd1, 1'b0, 7'd4, 15'd11), 11'd100, 104);
        pc_case("R7 stage lt equal not taken", f_rel(2'd2, 3'd1, 1'b0, 7'd4, 15'd10), 11'd100, 101);
        pc_case("R7 stage gt taken", f_rel(2'd2, 3'd2, 1'b0, 7'd4, 15'd9), 11'd100, 104);
        pc_case("R7 stage gt strict", f_rel(2'd2, 3'd2, 1'b0, 7'd4, 15'd10), 11'd100, 101);
        pc_case("R7 stage eq taken", f_rel(2'd2, 3'd4, 1'b1, 7'd4, 15'd10), 11'd100, 96);
        pc_case("R7 stage code 3 never", f_rel(2'd2, 3'd3, 1'b0, 7'd4, 15'd10), 11'd100, 101);
    endtask

    task automatic t_cmp_r0;
        r0 = 16'h8000;
        pc_case("R6 r0 high bit gt", f_rel(2'd0, 3'd2, 1'b0, 7'd8, 15'h7FFF), 11'd20, 28);
        pc_case("R6 r0 high bit not lt", f_rel(2'd0, 3'd1, 1'b0, 7'd8, 15'h7FFF), 11'd20, 21);
        r0 = 16'd300;
        pc_case("R6 r0 eq", f_rel(2'd0, 3'd4, 1'b0, 7'd8, 15'd300), 11'd20, 28);
        pc_case("R6 r0 gt strict", f_rel(2'd0, 3'd2, 1'b0, 7'd8, 15'd300), 11'd20, 21);
        pc_case("R6 r0 lt", f_rel(2'd0, 3'd1, 1'b0, 7'd8, 15'd301), 11'd20, 28);
        pc_case("R6 r0 code 0 never", f_rel(2'd0, 3'd0, 1'b0, 7'd8, 15'd300), 11'd20, 21);
    endtask

    task automatic t_offsets;
        r0 = 16'd0;
        pc_case("R8 backward wraps", f_rel(2'd0, 3'd4, 1'b1, 7'd7, 15'd0), 11'd5, 2046);
        pc_case("R8 forward max wraps", f_rel(2'd0, 3'd4, 1'b0, 7'd127, 15'd0), 11'd2040, 119);
        pc_case("R8 backward max", f_rel(2'd0, 3'd4, 1'b1, 7'd127, 15'd0), 11'd500, 373);
    endtask

    task automatic t_absolute;
        rv = 16'hF456;
        zf = 1'b0;
        of = 1'b0;
        pc_case("R9 direct imm", f_abs(3'd0, 1'b0, 11'h123), 11'd9, 11'h123);
        pc_case("R9 direct reg", f_abs(3'd0, 1'b1, 11'h123), 11'd9, 11'h456);
        pc_case("R9 zero clear not taken", f_abs(3'd1, 1'b0, 11'h200), 11'd9, 10);
        pc_case("R9 ovf clear not taken", f_abs(3'd2, 1'b0, 11'h200), 11'd9, 10);
        zf = 1'b1;
        pc_case("R9 zero set taken", f_abs(3'd1, 1'b0, 11'h200), 11'd9, 11'h200);
        pc_case("R9 zero does not drive ovf type", f_abs(3'd2, 1'b0, 11'h200), 11'd9, 10);
        of = 1'b1;
        pc_case("R9 ovf set taken", f_abs(3'd2, 1'b1, 11'h200), 11'd9, 11'h456);
        pc_case("R9 reserved type never", f_abs(3'd3, 1'b0, 11'h200), 11'd9, 10);
    endtask

    task automatic t_fallthrough;
        pc_case("R10 non-branch wraps", 32'h0000_0000, 11'd2047, 0);
        pc_case("R10 sub-opcode 3", {4'd8, 2'd3, 26'h3FF_FFFF}, 11'd40, 41);
        pc_case("R10 counter word", f_cnt(4'd0, 16'd1), 11'd41, 42);
    endtask

    initial begin
        t_reset();
        t_stage_ops();
        t_cmp_stage();
        t_cmp_r0();
        t_offsets();
        t_absolute();
        t_fallthrough();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule